// File: doc/BRIEF.md
# Inflight Packet Credit Release Counters

This block keeps a count of packets in flight for every load-balancer bucket and for every notification ring. An ingress dispatch port raises both counts when a packet is handed out. A memory-mapped release write lowers them again by a bulk amount. Each bucket entry also records the ring, group and mode of its most recent dispatch. A registered read port returns one bucket entry and one ring count.

A release write carries everything in its address word: the ring index, the bucket index, one enable bit for the ring counter, one for the bucket counter, and a region code that marks the access as a release. The write data carries the amount. The two enable bits are independent, so one write can lower a bucket, its ring, both, or neither. Counters saturate at both ends. A decrement past zero sets a sticky underflow flag, with one flag for the bucket table and one for the ring table.

Top module: `credit_release_ctr`

## Requirements
- R1: Release address fields are: ring index `rel_addr[10:3]`, bucket index `rel_addr[23:11]`, ring enable `rel_addr[24]`, bucket enable `rel_addr[25]`, region `rel_addr[28:26]`. The release amount is `rel_data[15:0]`. All other address and data bits have no effect.
- R2: A write with `rel_valid` high changes no counter unless the region field equals 4.
- R3: A release with the bucket enable set lowers the count of the addressed bucket by the amount.
- R4: A release with the ring enable set lowers the addressed ring count by the amount, independently of the bucket enable. With both enables clear the write has no effect.
- R5: A cycle with `disp_valid` high raises the named bucket count and the named ring count by one each. It also stores `disp_ring`, `disp_group` and `disp_mode` in the bucket entry.
- R6: When a dispatch and a release hit the same counter in one cycle, the counter takes the value old + 1 − amount.
- R7: A result below zero is stored as zero and sets the table's sticky flag (`bkt_uflow` or `ring_uflow`). Only reset clears a flag.
- R8: A count never wraps past 65535. Dispatches beyond that leave it at 65535.
- R9: A bucket index at or above `NUM_BKT`, or a ring index at or above `NUM_RING`, changes no counter in that table.
- R10: With `rd_en` high at a clock edge, `rd_valid` is high after that edge. The read outputs then show the entry of `rd_bkt` and the count of `rd_ring` as they stood before that edge, and zero for an out-of-range index. With `rd_en` low, `rd_valid` drops and the data outputs hold their values.
- R11: After reset, all counts, all entry fields, both flags and `rd_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rel_valid | input | 1 | Release write strobe |
| rel_addr | input | 32 | Release address word |
| rel_data | input | 32 | Release data word |
| disp_valid | input | 1 | Dispatch strobe |
| disp_bkt | input | 13 | Bucket being dispatched to |
| disp_ring | input | 8 | Ring assigned to that bucket |
| disp_group | input | 5 | Group recorded with the bucket |
| disp_mode | input | 3 | Mode recorded with the bucket |
| rd_en | input | 1 | Read request |
| rd_bkt | input | 13 | Bucket to read |
| rd_ring | input | 8 | Ring whose count is read |
| rd_valid | output | 1 | Read outputs were loaded at the last edge |
| rd_bkt_ring | output | 8 | Assigned ring of the read bucket |
| rd_bkt_cnt | output | 16 | Inflight count of the read bucket |
| rd_group | output | 5 | Group of the read bucket |
| rd_mode | output | 3 | Mode of the read bucket |
| rd_ring_cnt | output | 16 | Inflight count of the read ring |
| bkt_uflow | output | 1 | Sticky bucket underflow flag |
| ring_uflow | output | 1 | Sticky ring underflow flag |

## Verification
A dispatch or release takes effect at the edge where it is presented. A read issued at the next edge shows the new value one register stage later, and the bench samples 1 ns after that edge. The underflow flags are registered beside the counters, so they are sampled one cycle after the offending release. One case presents a release and a read in the same cycle and expects the pre-release value, which pins down the one-cycle ordering. Every check compares against a bench model that applies the saturating arithmetic of the requirements to each operation as it is driven.

// File: rtl/crc_pkg.sv
package crc_pkg;

    localparam int CNT_W     = 16;
    localparam int RING_W    = 8;
    localparam int BKT_W     = 13;
    localparam int GROUP_W   = 5;
    localparam int MODE_W    = 3;

    // release address layout (decoded by neighbours, so fixed)
    localparam int RING_LSB  = 3;
    localparam int BKT_LSB   = RING_LSB + RING_W;
    localparam int RING_EN_B = BKT_LSB + BKT_W;
    localparam int BKT_EN_B  = RING_EN_B + 1;
    localparam int REGION_LSB = BKT_EN_B + 1;
    localparam int REGION_W  = 3;
    localparam logic [REGION_W-1:0] RELEASE_REGION = 3'd4;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic              hit;
        logic              ring_en;
        logic              bkt_en;
        logic [RING_W-1:0] ring;
        logic [BKT_W-1:0]  bkt;
        cnt_t              amt;
    } rel_req_t;

    typedef struct packed {
        logic [RING_W-1:0]  ring;
        cnt_t               count;
        logic [GROUP_W-1:0] group;
        logic [MODE_W-1:0]  mode;
    } bkt_entry_t;

    typedef struct packed {
        cnt_t val;
        logic uflow;
    } step_res_t;

    // net update: cur + inc - dec, clamped to [0, max]
    function automatic step_res_t sat_step(cnt_t cur, logic inc, cnt_t dec);
        step_res_t         res;
        logic [CNT_W+1:0]  up;
        logic [CNT_W+1:0]  diff;
        up   = {2'b00, cur} + {{(CNT_W+1){1'b0}}, inc};
        diff = up - {2'b00, dec};
        if ({2'b00, dec} > up) begin
            res.val   = '0;
            res.uflow = 1'b1;
        end else if (diff[CNT_W+1:CNT_W] != 2'b00) begin
            res.val   = '1;
            res.uflow = 1'b0;
        end else begin
            res.val   = diff[CNT_W-1:0];
            res.uflow = 1'b0;
        end
        return res;
    endfunction

endpackage

// File: rtl/crc_rel_decode.sv
module crc_rel_decode
    import crc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              rel_valid,
    input  logic [ADDR_W-1:0] rel_addr,
    input  logic [DATA_W-1:0] rel_data,
    output rel_req_t          req
);
    localparam int REGION_MSB = REGION_LSB + REGION_W - 1;

    logic unused_bits;
    assign unused_bits = ^{rel_addr[RING_LSB-1:0], rel_addr[ADDR_W-1:REGION_MSB+1],
                           rel_data[DATA_W-1:CNT_W]};

    always_comb begin
        req.hit     = rel_valid && (rel_addr[REGION_MSB:REGION_LSB] == RELEASE_REGION);
        req.ring_en = rel_addr[RING_EN_B];
        req.bkt_en  = rel_addr[BKT_EN_B];
        req.ring    = rel_addr[BKT_LSB-1:RING_LSB];
        req.bkt     = rel_addr[RING_EN_B-1:BKT_LSB];
        req.amt     = rel_data[CNT_W-1:0];
    end
endmodule

// File: rtl/crc_bkt_table.sv
module crc_bkt_table
    import crc_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  rel_req_t           rel,
    input  logic               disp_valid,
    input  logic [BKT_W-1:0]   disp_bkt,
    input  logic [RING_W-1:0]  disp_ring,
    input  logic [GROUP_W-1:0] disp_group,
    input  logic [MODE_W-1:0]  disp_mode,
    input  logic [BKT_W-1:0]   rd_idx,
    output bkt_entry_t         rd_entry,
    output logic               uflow
);
    typedef struct packed {
        bkt_entry_t [DEPTH-1:0] tab;
        logic                   uflow;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < DEPTH; i++) begin : g_entry
            logic      inc_e;
            cnt_t      dec_e;
            step_res_t r_e;
            inc_e = disp_valid && (disp_bkt == BKT_W'(i));
            dec_e = (rel.hit && rel.bkt_en && (rel.bkt == BKT_W'(i))) ? rel.amt : '0;
            r_e   = sat_step(s_q.tab[i].count, inc_e, dec_e);
            s_d.tab[i].count = r_e.val;
            if (r_e.uflow) s_d.uflow = 1'b1;
            if (inc_e) begin
                s_d.tab[i].ring  = disp_ring;
                s_d.tab[i].group = disp_group;
                s_d.tab[i].mode  = disp_mode;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rd_entry = '0;
        for (int i = 0; i < DEPTH; i++)
            if (rd_idx == BKT_W'(i)) rd_entry = s_q.tab[i];
    end

    assign uflow = s_q.uflow;
endmodule

// File: rtl/crc_ring_table.sv
module crc_ring_table
    import crc_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rel_req_t          rel,
    input  logic              disp_valid,
    input  logic [RING_W-1:0] disp_ring,
    input  logic [RING_W-1:0] rd_idx,
    output cnt_t              rd_cnt,
    output logic              uflow
);
    typedef struct packed {
        cnt_t [DEPTH-1:0] cnt;
        logic             uflow;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < DEPTH; i++) begin : g_ring
            logic      inc_r;
            cnt_t      dec_r;
            step_res_t r_r;
            inc_r = disp_valid && (disp_ring == RING_W'(i));
            dec_r = (rel.hit && rel.ring_en && (rel.ring == RING_W'(i))) ? rel.amt : '0;
            r_r   = sat_step(s_q.cnt[i], inc_r, dec_r);
            s_d.cnt[i] = r_r.val;
            if (r_r.uflow) s_d.uflow = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rd_cnt = '0;
        for (int i = 0; i < DEPTH; i++)
            if (rd_idx == RING_W'(i)) rd_cnt = s_q.cnt[i];
    end

    assign uflow = s_q.uflow;
endmodule

// File: rtl/credit_release_ctr.sv
module credit_release_ctr
    import crc_pkg::*;
#(
    parameter int NUM_BKT  = 64,
    parameter int NUM_RING = 16,
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rel_valid,
    input  logic [ADDR_W-1:0] rel_addr,
    input  logic [DATA_W-1:0] rel_data,
    input  logic              disp_valid,
    input  logic [12:0]       disp_bkt,
    input  logic [7:0]        disp_ring,
    input  logic [4:0]        disp_group,
    input  logic [2:0]        disp_mode,
    input  logic              rd_en,
    input  logic [12:0]       rd_bkt,
    input  logic [7:0]        rd_ring,
    output logic              rd_valid,
    output logic [7:0]        rd_bkt_ring,
    output logic [15:0]       rd_bkt_cnt,
    output logic [4:0]        rd_group,
    output logic [2:0]        rd_mode,
    output logic [15:0]       rd_ring_cnt,
    output logic              bkt_uflow,
    output logic              ring_uflow
);
    typedef struct packed {
        logic       vld;
        bkt_entry_t ent;
        cnt_t       rcnt;
    } rd_st_t;

    rel_req_t   rel;
    bkt_entry_t bkt_view;
    cnt_t       ring_view;
    rd_st_t     r_d, r_q;

    crc_rel_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .rel_valid (rel_valid),
        .rel_addr  (rel_addr),
        .rel_data  (rel_data),
        .req       (rel)
    );

    crc_bkt_table #(.DEPTH(NUM_BKT)) u_bkt (
        .clk        (clk),
        .rst_n      (rst_n),
        .rel        (rel),
        .disp_valid (disp_valid),
        .disp_bkt   (disp_bkt),
        .disp_ring  (disp_ring),
        .disp_group (disp_group),
        .disp_mode  (disp_mode),
        .rd_idx     (rd_bkt),
        .rd_entry   (bkt_view),
        .uflow      (bkt_uflow)
    );

    crc_ring_table #(.DEPTH(NUM_RING)) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .rel        (rel),
        .disp_valid (disp_valid),
        .disp_ring  (disp_ring),
        .rd_idx     (rd_ring),
        .rd_cnt     (ring_view),
        .uflow      (ring_uflow)
    );

    always_comb begin
        r_d     = r_q;
        r_d.vld = rd_en;
        if (rd_en) begin
            r_d.ent  = bkt_view;
            r_d.rcnt = ring_view;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_valid    = r_q.vld;
    assign rd_bkt_ring = r_q.ent.ring;
    assign rd_bkt_cnt  = r_q.ent.count;
    assign rd_group    = r_q.ent.group;
    assign rd_mode     = r_q.ent.mode;
    assign rd_ring_cnt = r_q.rcnt;
endmodule

// File: rtl/credit_release_ctr_chk.sv
module credit_release_ctr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rel_valid,
    input logic [31:0] rel_addr,
    input logic        rd_en,
    input logic        rd_valid,
    input logic [15:0] rd_bkt_cnt,
    input logic [15:0] rd_ring_cnt,
    input logic        bkt_uflow,
    input logic        ring_uflow
);
    // R10
    rd_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R10
    rd_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!rd_valid && $stable(rd_bkt_cnt) && $stable(rd_ring_cnt)));

    // R7
    bkt_uflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bkt_uflow |=> bkt_uflow);

    // R7
    ring_uflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ring_uflow |=> ring_uflow);

    // R3
    bkt_uflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bkt_uflow) |-> $past(rel_valid && rel_addr[25] && rel_addr[28:26] == 3'd4));

    // R4
    ring_uflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ring_uflow) |-> $past(rel_valid && rel_addr[24] && rel_addr[28:26] == 3'd4));
endmodule

bind credit_release_ctr credit_release_ctr_chk u_chk (.*);

// File: tb/sim_credit_release_ctr.sv
`timescale 1ns/1ps
module sim_credit_release_ctr;
    localparam int NB = 64;
    localparam int NR = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rel_valid = 1'b0;
    logic [31:0] rel_addr = '0;
    logic [31:0] rel_data = '0;
    logic        disp_valid = 1'b0;
    logic [12:0] disp_bkt = '0;
    logic [7:0]  disp_ring = '0;
    logic [4:0]  disp_group = '0;
    logic [2:0]  disp_mode = '0;
    logic        rd_en = 1'b0;
    logic [12:0] rd_bkt = '0;
    logic [7:0]  rd_ring = '0;
    logic        rd_valid;
    logic [7:0]  rd_bkt_ring;
    logic [15:0] rd_bkt_cnt;
    logic [4:0]  rd_group;
    logic [2:0]  rd_mode;
    logic [15:0] rd_ring_cnt;
    logic        bkt_uflow, ring_uflow;

    credit_release_ctr u0 (.*);

    always #2 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    int m_bc[NB]; int m_br[NB]; int m_bg[NB]; int m_bm[NB];
    int m_rc[NR];
    bit m_bu = 0, m_ru = 0;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int net(int cur, int inc, int dec, ref bit flag);
        int v = cur + inc - dec;
        if (v < 0) begin v = 0; flag = 1; end
        if (v > 65535) v = 65535;
        return v;
    endfunction

    // address built from the R1 layout, with junk in the ignored bits
    function automatic logic [31:0] mk(int ring, int bkt, bit ren, bit ben, int region);
        return {3'b101, 3'(region), ben, ren, 13'(bkt), 8'(ring), 3'b110};
    endfunction

    task automatic step();
        @(posedge clk); #1;
    endtask

    // one cycle with optional dispatch and release; model updated alongside
    task automatic op(bit dv, int db, int dr, int dg, int dm,
                      bit rv, int rr, int rb, bit ren, bit ben, int region, int amt);
        bit rel_ok = rv && region == 4;
        int bi, bd, ri, rd2;
        disp_valid = dv; disp_bkt = 13'(db); disp_ring = 8'(dr);
        disp_group = 5'(dg); disp_mode = 3'(dm);
        rel_valid = rv; rel_addr = mk(rr, rb, ren, ben, region);
        rel_data = {16'hBEEF, 16'(amt)};
        step();
        disp_valid = 0; rel_valid = 0;
        for (int b = 0; b < NB; b++) begin
            bi = (dv && db == b) ? 1 : 0;
            bd = (rel_ok && ben && rb == b) ? amt : 0;
            if (bi || bd) m_bc[b] = net(m_bc[b], bi, bd, m_bu);
            if (bi) begin m_br[b] = dr; m_bg[b] = dg; m_bm[b] = dm; end
        end
        for (int r = 0; r < NR; r++) begin
            ri = (dv && dr == r) ? 1 : 0;
            rd2 = (rel_ok && ren && rr == r) ? amt : 0;
            if (ri || rd2) m_rc[r] = net(m_rc[r], ri, rd2, m_ru);
        end
    endtask

    task automatic rd(int b, int r);
        rd_en = 1; rd_bkt = 13'(b); rd_ring = 8'(r);
        step();
        rd_en = 0;
    endtask

    task automatic check_all(string req);
        for (int b = 0; b < NB; b++) begin
            rd(b, b % NR);
            chk(req, rd_valid, 1);
            chk(req, rd_bkt_cnt, m_bc[b]);
            chk(req, rd_bkt_ring, m_br[b]);
            chk(req, rd_group, m_bg[b]);
            chk(req, rd_mode, m_bm[b]);
            chk(req, rd_ring_cnt, m_rc[b % NR]);
        end
        chk(req, bkt_uflow, m_bu);
        chk(req, ring_uflow, m_ru);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int hold_b, hold_r;
        for (int i = 0; i < NB; i++) begin m_bc[i] = 0; m_br[i] = 0; m_bg[i] = 0; m_bm[i] = 0; end
        for (int i = 0; i < NR; i++) m_rc[i] = 0;
        #1; step(); step();
        // R11 reset state
        chk("R11", rd_valid, 0); chk("R11", bkt_uflow, 0); chk("R11", ring_uflow, 0);
        rst_n = 1; step();
        check_all("R11");

        // R5 dispatch sweep over every bucket
        for (int b = 0; b < NB; b++)
            for (int k = 0; k <= b % 5; k++)
                op(1, b, b % NR, (b * 7 + k) % 32, (b + k) % 8, 0, 0, 0, 0, 0, 4, 0);
        check_all("R5");

        // R3/R4/R1 releases with each enable combination
        for (int b = 0; b < NB; b++)
            op(0, 0, 0, 0, 0, 1, (b * 3) % NR, b, b[0], b[1], 4, 1 + (b % 2));
        check_all("R4");
        check_all("R3");

        // R2 wrong regions do nothing
        for (int g = 0; g < 8; g++)
            if (g != 4) op(0, 0, 0, 0, 0, 1, 2, 9, 1, 1, g, 1);
        check_all("R2");

        // R9 out-of-range indices
        op(1, 64, 20, 3, 3, 0, 0, 0, 0, 0, 4, 0);
        op(0, 0, 0, 0, 0, 1, 40, 100, 1, 1, 4, 1);
        op(1, 7, 30, 1, 1, 0, 0, 0, 0, 0, 4, 0);
        rd(64, 20);
        chk("R9", rd_bkt_cnt, 0); chk("R9", rd_ring_cnt, 0);
        check_all("R9");

        // R6 same-cycle dispatch and release on one bucket and ring
        op(1, 10, 10, 4, 2, 1, 10, 10, 1, 1, 4, 2);
        op(1, 11, 11, 4, 2, 1, 11, 11, 1, 1, 4, 1);
        check_all("R6");

        // R7 bucket underflow only
        op(0, 0, 0, 0, 0, 1, 0, 20, 0, 1, 4, 500);
        rd(20, 0);
        chk("R7", rd_bkt_cnt, 0); chk("R7", bkt_uflow, 1); chk("R7", ring_uflow, 0);
        op(0, 0, 0, 0, 0, 1, 3, 0, 1, 0, 4, 60000);
        op(1, 20, 5, 0, 0, 0, 0, 0, 0, 0, 4, 0);
        check_all("R7");

        // R10 read sees the state from before the edge
        hold_b = m_bc[30]; hold_r = m_rc[14];
        rd_en = 1; rd_bkt = 30; rd_ring = 14;
        op(0, 0, 0, 0, 0, 1, 14, 30, 1, 1, 4, 1);
        rd_en = 0;
        chk("R10", rd_bkt_cnt, hold_b); chk("R10", rd_ring_cnt, hold_r);
        op(1, 30, 14, 0, 0, 0, 0, 0, 0, 0, 4, 0);
        chk("R10", rd_valid, 0); chk("R10", rd_bkt_cnt, hold_b); chk("R10", rd_ring_cnt, hold_r);

        // R8 saturation at the top
        disp_valid = 1; disp_bkt = 5; disp_ring = 5; disp_group = 2; disp_mode = 1;
        repeat (65600) step();
        disp_valid = 0;
        m_bc[5] = 65535; m_rc[5] = 65535; m_br[5] = 5; m_bg[5] = 2; m_bm[5] = 1;
        rd(5, 5);
        chk("R8", rd_bkt_cnt, 65535); chk("R8", rd_ring_cnt, 65535);
        op(1, 5, 5, 2, 1, 1, 5, 5, 1, 1, 4, 3);
        rd(5, 5);
        chk("R8", rd_bkt_cnt, 65533); chk("R8", rd_ring_cnt, 65533);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule